// File: doc/BRIEF.md
# Bus Cycle Length Controller

This block sets the length of every processor bus cycle by timing the processor's cache-miss and continue inputs. A cycle starts when the active-low address latch enable falls. At that point the block classifies the cycle from the latched cycle code, the bank code and the upper address bits. Reads from memory are reported as cache hits and finish early. Writes to the external I/O bank are stretched so that slow peripheral write strobes meet their minimum width. Every other cycle keeps the default length.

The block also flags memory-bank accesses that fall above the installed memory. No cache storage exists: the three cycle lengths come only from how the miss flag is reported and when the continue pulse is released. When the processor is between cycles, all three outputs stay low.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After reset, and until the first bus cycle starts, `miss_o`, `cont_o` and `nxm_o` are low. `ale_ni` is taken as high at reset.
- R2: Memory reads complete with `cont_o` high in clock 4. Memory reads are bank `00` with cycle code `1100` or `10xx`. `miss_o` stays low for the whole cycle. Clock 1 is the period after the clock edge that first samples `ale_ni` low.
- R3: External I/O writes complete with `cont_o` high in clock 10. External I/O writes are bank `10` with cycle code `00xx`. `miss_o` is high for the whole cycle.
- R4: All other cycles complete with `cont_o` high in clock 8 and `miss_o` high. This covers memory writes, general-purpose reads `1110` and writes `0101`, I/O reads, and system-bank accesses.
- R5: `cont_o` is high for exactly one clock per cycle. `miss_o` and `nxm_o` fall in the clock after that pulse.
- R6: A cycle with code `1111` (no access) produces no wait states. `cont_o`, `miss_o` and `nxm_o` all stay low, whatever the bank and address.
- R7: `nxm_o` is high from clock 1 through the continue clock when all of the following hold: the bank is `00`, the code is not `1111`, and the upper address bits (address 21..18 with the default 256 KB installed) are not all zero. The cycle length is unchanged. For any other bank, `nxm_o` stays low.
- R8: A new falling edge of `ale_ni` during a cycle abandons that cycle and restarts the count with the new cycle's length.
- R9: Holding `ale_ni` low does not start further cycles; only a high-to-low transition does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ale_ni | input | 1 | Address latch enable, active low; its falling edge starts a cycle |
| cyc_code_i | input | 4 | Latched bus cycle type code |
| bank_i | input | 2 | Latched bank code (00 memory, 01 system, 10 external I/O, 11 internal) |
| addr_hi_i | input | HI_W (4) | Latched upper address bits 21..18 |
| miss_o | output | 1 | Cache miss report; low means hit |
| cont_o | output | 1 | One-clock pulse that ends the bus cycle |
| nxm_o | output | 1 | Non-existent memory flag |

## Verification
The bench builds the block with its default parameters. The three lengths are 4, 8 and 10 clocks, with four upper address bits and none of them installed. This places every memory-bank access with any of address bits 21..18 set in non-existent memory, so the error flag can be reached with single-bit addresses at both ends of that field. The ten-clock I/O write is also long enough that an early restart can be told apart from a cycle that runs to its end.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_FAST = 2'd1,
    CLS_BASE = 2'd2,
    CLS_SLOW = 2'd3
  } cyc_cls_e;

  localparam logic [1:0] BANK_MEM = 2'b00;
  localparam logic [1:0] BANK_IO  = 2'b10;
  localparam logic [3:0] CODE_NIO = 4'b1111;
  localparam logic [3:0] CODE_IRD = 4'b1100;
endpackage

// File: rtl/bcc_decode.sv
module bcc_decode
  import bcc_pkg::*;
#(
  parameter int HI_W     = 4,
  parameter int INST_HI  = 0
) (
  input  logic [3:0]      code_i,
  input  logic [1:0]      bank_i,
  input  logic [HI_W-1:0] addr_hi_i,
  output cyc_cls_e        cls_o,
  output logic            nxm_o
);
  logic is_read, is_write, is_nio, hi_miss;

  assign is_nio   = (code_i == CODE_NIO);
  assign is_read  = (code_i == CODE_IRD) || (code_i[3:2] == 2'b10);
  assign is_write = (code_i[3:2] == 2'b00);

  always_comb begin
    if (is_nio)                              cls_o = CLS_NONE;
    else if (bank_i == BANK_MEM && is_read)  cls_o = CLS_FAST;
    else if (bank_i == BANK_IO && is_write)  cls_o = CLS_SLOW;
    else                                     cls_o = CLS_BASE;
  end

  // upper bits at or above INST_HI have no memory behind them
  generate
    if (INST_HI >= HI_W) begin : g_full
      assign hi_miss = 1'b0;
    end else begin : g_part
      logic [HI_W-1:0] mask;
      always_comb begin
        for (int i = 0; i < HI_W; i++) mask[i] = (i >= INST_HI);
      end
      assign hi_miss = |(addr_hi_i & mask);
    end
  endgenerate

  assign nxm_o = !is_nio && (bank_i == BANK_MEM) && hi_miss;
endmodule

// File: rtl/bcc_timer.sv
module bcc_timer
  import bcc_pkg::*;
#(
  parameter int FAST_LEN = 4,
  parameter int BASE_LEN = 8,
  parameter int SLOW_LEN = 10,
  parameter int CNT_W    = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  cyc_cls_e cls_i,
  output logic     active_o,
  output logic     cont_o
);
  logic [CNT_W-1:0] cnt_q, tgt_q, tgt_d;
  logic             active_q;

  always_comb begin
    unique case (cls_i)
      CLS_FAST: tgt_d = CNT_W'(FAST_LEN);
      CLS_SLOW: tgt_d = CNT_W'(SLOW_LEN);
      default:  tgt_d = CNT_W'(BASE_LEN);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      tgt_q    <= '0;
    end else if (start_i) begin
      active_q <= (cls_i != CLS_NONE);
      cnt_q    <= CNT_W'(1);
      tgt_q    <= tgt_d;
    end else if (active_q) begin
      if (cnt_q == tgt_q) active_q <= 1'b0;
      else                cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign cont_o   = active_q && (cnt_q == tgt_q);

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q <= tgt_q));
  p_cont_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont_o |=> !cont_o);
  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cls_i != CLS_NONE) |=> (active_q && cnt_q == CNT_W'(1)));
  p_nio_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cls_i == CLS_NONE) |=> !active_q);
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
#(
  parameter int FAST_LEN = 4,
  parameter int BASE_LEN = 8,
  parameter int SLOW_LEN = 10,
  parameter int HI_W     = 4,
  parameter int INST_HI  = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ale_ni,
  input  logic [3:0]      cyc_code_i,
  input  logic [1:0]      bank_i,
  input  logic [HI_W-1:0] addr_hi_i,
  output logic            miss_o,
  output logic            cont_o,
  output logic            nxm_o
);
  localparam int MAX_LEN = (SLOW_LEN > BASE_LEN) ?
                           ((SLOW_LEN > FAST_LEN) ? SLOW_LEN : FAST_LEN) :
                           ((BASE_LEN > FAST_LEN) ? BASE_LEN : FAST_LEN);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  cyc_cls_e cls;
  logic     ale_q, start, nxm_hit, active, miss_q, nxm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ale_q <= 1'b1;
    else         ale_q <= ale_ni;
  end
  assign start = ale_q && !ale_ni;

  bcc_decode #(.HI_W(HI_W), .INST_HI(INST_HI)) u_decode (
    .code_i    (cyc_code_i),
    .bank_i    (bank_i),
    .addr_hi_i (addr_hi_i),
    .cls_o     (cls),
    .nxm_o     (nxm_hit)
  );

  bcc_timer #(
    .FAST_LEN(FAST_LEN), .BASE_LEN(BASE_LEN),
    .SLOW_LEN(SLOW_LEN), .CNT_W(CNT_W)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .cls_i    (cls),
    .active_o (active),
    .cont_o   (cont_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      miss_q <= 1'b0;
      nxm_q  <= 1'b0;
    end else if (start) begin
      miss_q <= (cls == CLS_BASE) || (cls == CLS_SLOW);
      nxm_q  <= nxm_hit;
    end
  end

  assign miss_o = active && miss_q;
  assign nxm_o  = active && nxm_q;

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (!miss_o && !nxm_o && !cont_o));
  p_nxm_bank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && bank_i != BANK_MEM) |=> !nxm_o);
  p_hit_fast_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && bank_i == BANK_MEM && cyc_code_i == CODE_IRD) |=> !miss_o);
  p_fall_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ale_q && !ale_ni && !cont_o) |=> $stable(active));
endmodule

// File: tb/bus_cycle_ctrl_test.sv
module bus_cycle_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ale_ni = 1'b1;
  logic [3:0] cyc_code_i = 4'b1111;
  logic [1:0] bank_i = 2'b00;
  logic [3:0] addr_hi_i = 4'b0000;
  logic       miss_o, cont_o, nxm_o;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  always #5 clk_i = ~clk_i;

  bus_cycle_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ale_ni(ale_ni), .cyc_code_i(cyc_code_i),
    .bank_i(bank_i), .addr_hi_i(addr_hi_i),
    .miss_o(miss_o), .cont_o(cont_o), .nxm_o(nxm_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // exp_len 0: no continue pulse expected
  task automatic run_cycle(input logic [3:0] code, input logic [1:0] bank,
                           input logic [3:0] hi, input int exp_len,
                           input bit exp_miss, input bit exp_nxm,
                           input bit hold, input string req);
    int first = 0, pulses = 0;
    @(negedge clk_i);
    ale_ni = 1'b0; cyc_code_i = code; bank_i = bank; addr_hi_i = hi;
    for (int k = 1; k <= 13; k++) begin
      @(negedge clk_i);
      if (k == 1) begin
        chk(miss_o == exp_miss, {req, " miss"}, miss_o, exp_miss);
        chk(nxm_o == exp_nxm, {req, " nxm"}, nxm_o, exp_nxm);
        if (!hold) ale_ni = 1'b1;
      end
      if (cont_o) begin
        pulses++;
        if (first == 0) begin
          first = k;
          chk(nxm_o == exp_nxm, {req, " nxm at cont"}, nxm_o, exp_nxm);
        end
      end
    end
    ale_ni = 1'b1;
    chk(first == exp_len, {req, " length"}, first, exp_len);
    chk(pulses == (exp_len == 0 ? 0 : 1), "R5 pulse count", pulses, exp_len == 0 ? 0 : 1);
    chk(!miss_o && !nxm_o, "R5 idle after cycle", {miss_o, nxm_o}, 0);
  endtask

  task automatic t_reset;
    chk(!miss_o && !cont_o && !nxm_o, "R1 reset outputs", {miss_o, cont_o, nxm_o}, 0);
  endtask

  task automatic t_mem_read;
    run_cycle(4'b1100, 2'b00, 4'h0, 4, 0, 0, 0, "R2 instr read");
    run_cycle(4'b1001, 2'b00, 4'h0, 4, 0, 0, 0, "R2 data read");
    run_cycle(4'b1010, 2'b00, 4'h0, 4, 0, 0, 0, "R2 rmw read");
    run_cycle(4'b1000, 2'b00, 4'h0, 4, 0, 0, 0, "R2 demand read");
  endtask

  task automatic t_io_write;
    run_cycle(4'b0011, 2'b10, 4'h0, 10, 1, 0, 0, "R3 io byte write");
    run_cycle(4'b0001, 2'b10, 4'h0, 10, 1, 0, 0, "R3 io word write");
  endtask

  task automatic t_default;
    run_cycle(4'b0001, 2'b00, 4'h0, 8, 1, 0, 0, "R4 mem write");
    run_cycle(4'b1001, 2'b10, 4'h0, 8, 1, 0, 0, "R4 io read");
    run_cycle(4'b1110, 2'b00, 4'h0, 8, 1, 0, 0, "R4 gp read");
    run_cycle(4'b0101, 2'b10, 4'h0, 8, 1, 0, 0, "R4 gp write");
    run_cycle(4'b1001, 2'b01, 4'h0, 8, 1, 0, 0, "R4 system read");
  endtask

  task automatic t_nio;
    run_cycle(4'b1111, 2'b00, 4'h0, 0, 0, 0, 0, "R6 nio");
    run_cycle(4'b1111, 2'b00, 4'hF, 0, 0, 0, 0, "R6 nio high addr");
  endtask

  task automatic t_nxm;
    run_cycle(4'b1001, 2'b00, 4'h1, 4, 0, 1, 0, "R7 read bit18");
    run_cycle(4'b0001, 2'b00, 4'h8, 8, 1, 1, 0, "R7 write bit21");
    run_cycle(4'b0001, 2'b10, 4'hF, 10, 1, 0, 0, "R7 io bank");
  endtask

  task automatic t_restart;
    int early = 0;
    @(negedge clk_i);
    ale_ni = 1'b0; cyc_code_i = 4'b0001; bank_i = 2'b10; addr_hi_i = 4'h0;
    @(negedge clk_i); ale_ni = 1'b1; if (cont_o) early++;
    @(negedge clk_i); if (cont_o) early++;
    chk(early == 0, "R8 no early cont", early, 0);
    run_cycle(4'b1100, 2'b00, 4'h0, 4, 0, 0, 0, "R8 restart");
  endtask

  task automatic t_hold;
    run_cycle(4'b1100, 2'b00, 4'h0, 4, 0, 0, 1, "R9 ale held low");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset;
    t_mem_read;
    t_io_write;
    t_default;
    t_nio;
    t_nxm;
    t_restart;
    t_hold;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule